// File: doc/BRIEF.md
# SPI Flash Command Front End

This block is the serial slave side of a byte-wide serial flash device. It takes the four slave pins (clock, select, data in, pause) into a fast system clock domain, assembles opcode, address and data bytes most significant bit first, and turns each complete write-side frame into a one-cycle command strobe for the array and protection logic behind it. For read-side frames it fetches bytes (array data, a status byte supplied from outside, or a fixed identification pair) and shifts them out on the serial output.

Both clock polarities used by the common modes (idle low and idle high) are handled the same way: input bits are sampled on rising serial clock edges and the output changes on falling edges. A pause input freezes a frame without losing its place. While the write engine reports a cycle in progress, every opcode except the status read is ignored. An opcode the block does not know silences it until the select line is released and asserted again.

Top module: `sflash_cmd_front`

## Requirements
- R1: The opcode is the first byte after select falls, and its bit 3 is ignored: 0x06 enables writes, 0x04 disables writes, 0x05 reads status, 0x01 writes status, 0x03 reads data, 0x02 programs, 0x52 erases a sector, 0x62 erases the chip, 0x15 reads the identification bytes.
- R2: Every address and data byte is shifted most significant bit first; of the three address bytes only the low 18 bits are used and bits 23..18 are ignored.
- R3: While select is high, no command strobe is issued and the output enable stays low; a frame is cut short by select rising.
- R4: After an unknown opcode, no strobe, no array fetch and no output enable occur until select rises and falls again; the following frame decodes normally.
- R5: Pause low while the serial clock is low freezes the frame: the output enable drops, clock and data activity are ignored, and after pause returns high (clock low) the frame continues where it stopped.
- R6: The data read streams bytes from the given address upward, one array fetch per byte, with the address wrapping from 0x3FFFF to 0x00000.
- R7: The identification read returns 0x1F, then 0x63, then 0x00 for every later byte.
- R8: The status read returns the external status byte on every output byte and is accepted while a write cycle is in progress.
- R9: While the busy input is high when the opcode completes, any opcode other than the status read produces no strobe, no fetch and no output enable.
- R10: A program frame issues one strobe per complete data byte (kind 4, data valid set), the address advancing in its low 8 bits only, so it wraps inside the 256-byte page.
- R11: A status write issues one strobe (kind 3, data valid set) for its first data byte; later bytes are ignored.
- R12: Write enable (kind 1) and write disable (kind 2) strobe when their opcode completes; sector erase (kind 5) and chip erase (kind 6) strobe with the parsed address after the third address byte, data valid clear.
- R13: Each command strobe lasts exactly one system clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Select, active low |
| spi_si | input | 1 | Serial data into the block |
| spi_hold_n | input | 1 | Pause, active low |
| spi_so | output | 1 | Serial data out of the block |
| spi_so_oe | output | 1 | Output enable for the serial data pad |
| wr_busy | input | 1 | Write cycle in progress, from the write engine |
| status_byte | input | 8 | Status byte returned by the status read |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_kind | output | 4 | Command kind (1..6, see R10 to R12) |
| cmd_addr | output | 18 | Parsed array address |
| cmd_data | output | 8 | Data byte for program and status write |
| cmd_has_data | output | 1 | cmd_data is meaningful |
| rd_req | output | 1 | Array read request |
| rd_addr | output | 18 | Array read address |
| rd_data | input | 8 | Array read data, valid the cycle after rd_req |

## Verification
The hardest state to reach is a pause landing in the middle of a byte while the block is already driving output, with the serial clock toggling and the data line carrying noise during the pause; the frame must then resume with both the input and output bit counters intact. The stimulus gets there by letting each frame carry an optional pause point (byte and bit chosen at random) at which the driver drops pause, toggles the clock with random data, and releases it. Reads near the top of the array and program runs that start late in a page are directed to hit the two wrap points.

// File: rtl/sfc_pkg.sv
// Shared types for the serial flash command front end.
// Assumes: opcodes are compared with bit 3 masked off.
package sfc_pkg;

    typedef enum logic [3:0] {
        CK_NONE   = 4'd0,
        CK_WREN   = 4'd1,
        CK_WRDI   = 4'd2,
        CK_WRSR   = 4'd3,
        CK_PROG   = 4'd4,
        CK_SERASE = 4'd5,
        CK_CERASE = 4'd6,
        CK_READ   = 4'd7,
        CK_RDSR   = 4'd8,
        CK_RDID   = 4'd9,
        CK_BAD    = 4'd15
    } cmd_kind_e;

    typedef enum logic [2:0] {
        ST_OP,
        ST_ADDR,
        ST_DATA,
        ST_TX,
        ST_IGN
    } frame_state_e;

    // Map a received opcode byte to a command kind, bit 3 ignored.
    function automatic cmd_kind_e decode_op(input logic [7:0] op);
        logic [7:0] m;
        m = op & 8'hF7;
        case (m)
            8'h06:   return CK_WREN;
            8'h04:   return CK_WRDI;
            8'h05:   return CK_RDSR;
            8'h01:   return CK_WRSR;
            8'h03:   return CK_READ;
            8'h02:   return CK_PROG;
            8'h52:   return CK_SERASE;
            8'h62:   return CK_CERASE;
            8'h15:   return CK_RDID;
            default: return CK_BAD;
        endcase
    endfunction

endpackage

// File: rtl/sfc_sync.sv
// Per-bit multi-flop synchroniser bank.
// Assumes: each bit is an independent slow level; RST_VAL gives the idle level.
module sfc_sync #(
    parameter int W = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        // Shift the asynchronous level through STAGES flops.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], d[g]};
        end
        assign q[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/sfc_pin_front.sv
// Synchronises the serial pins and turns the clock into edge pulses.
// Edges are reported only while selected and not paused. The pause
// state changes only while the synchronised serial clock is low.
module sfc_pin_front #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    input  logic hold_n,
    output logic sel,
    output logic paused,
    output logic rise,
    output logic fall,
    output logic si_s
);
    logic [3:0] pins_s;
    logic       sck_s, cs_s, hold_s, sck_d;

    sfc_sync #(.W(4), .STAGES(STAGES), .RST_VAL(4'b1010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({hold_n, si, cs_n, sck}),
        .q(pins_s)
    );

    assign sck_s  = pins_s[0];
    assign cs_s   = pins_s[1];
    assign si_s   = pins_s[2];
    assign hold_s = pins_s[3];

    // Remember the previous clock level and track the pause state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d  <= 1'b0;
            paused <= 1'b0;
        end else begin
            sck_d <= sck_s;
            if (cs_s)        paused <= 1'b0;
            else if (!sck_s) paused <= !hold_s;
        end
    end

    assign sel  = !cs_s;
    assign rise = sel && !paused && sck_s && !sck_d;
    assign fall = sel && !paused && !sck_s && sck_d;
endmodule

// File: rtl/sfc_tx.sv
// Output shifter: places one bit per falling edge, MSB first.
// Assumes the next byte is loaded within a few cycles after need_next,
// well before the following falling edge.
module sfc_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       fall,
    input  logic       load,
    input  logic [7:0] load_byte,
    output logic       so_bit,
    output logic       need_next
);
    logic [7:0] byte_q;
    logic [2:0] idx;

    // Hold the byte being sent, step the bit index, drive the pad bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
            idx    <= '0;
            so_bit <= 1'b0;
        end else begin
            if (load) byte_q <= load_byte;
            if (clear) begin
                idx <= '0;
            end else if (fall) begin
                so_bit <= byte_q[3'd7 - idx];
                idx    <= idx + 3'd1;
            end
        end
    end

    assign need_next = fall && !clear && (idx == 3'd7);
endmodule

// File: rtl/sflash_cmd_front.sv
// Serial flash slave front end: frame parser, command strobe and
// read-side response. Assumes the system clock runs at least twelve
// times faster than the serial clock and that wr_busy and status_byte
// are synchronous to clk.
module sflash_cmd_front
    import sfc_pkg::*;
#(
    parameter int ADDR_W      = 18,
    parameter int ADDR_BYTES  = 3,
    parameter int PAGE_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter logic [7:0] ID_MFR = 8'h1F,
    parameter logic [7:0] ID_DEV = 8'h63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_si,
    input  logic              spi_hold_n,
    output logic              spi_so,
    output logic              spi_so_oe,
    input  logic              wr_busy,
    input  logic [7:0]        status_byte,
    output logic              cmd_valid,
    output logic [3:0]        cmd_kind,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [7:0]        cmd_data,
    output logic              cmd_has_data,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data
);
    localparam int FRAME_AW = ADDR_BYTES * 8;
    localparam int BC_W     = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam logic [BC_W-1:0] LAST_AB = BC_W'(ADDR_BYTES - 1);

    logic sel, paused, rise, fall, si_s;
    logic so_bit, need_next, tx_load;
    logic [7:0] tx_byte;

    frame_state_e        state;
    cmd_kind_e           kind_q, op_kind, fetch_kind;
    logic [2:0]          bit_q;
    logic [BC_W-1:0]     ab_q;
    logic [7:0]          shreg, rx_byte;
    logic [FRAME_AW-1:0] addr_acc, full_addr;
    logic [ADDR_W-1:0]   addr_q, fetch_addr;
    logic [1:0]          id_q, id_sel;
    logic                load_p1, load_p2;
    logic                byte_done, enter_tx, fetch;

    sfc_pin_front #(.STAGES(SYNC_STAGES)) u_pins (
        .clk(clk), .rst_n(rst_n),
        .sck(spi_sck), .cs_n(spi_cs_n), .si(spi_si), .hold_n(spi_hold_n),
        .sel(sel), .paused(paused), .rise(rise), .fall(fall), .si_s(si_s)
    );

    sfc_tx u_tx (
        .clk(clk), .rst_n(rst_n),
        .clear(!sel),
        .fall(fall && state == ST_TX),
        .load(tx_load), .load_byte(tx_byte),
        .so_bit(so_bit), .need_next(need_next)
    );

    // Byte assembly, decode of the finished byte, and fetch selection.
    always_comb begin
        rx_byte    = {shreg[6:0], si_s};
        op_kind    = decode_op(rx_byte);
        full_addr  = {addr_acc[FRAME_AW-9:0], rx_byte};
        byte_done  = rise && bit_q == 3'd7 &&
                     (state == ST_OP || state == ST_ADDR || state == ST_DATA);
        enter_tx   = byte_done &&
                     ((state == ST_OP && (op_kind == CK_RDSR ||
                                          (op_kind == CK_RDID && !wr_busy))) ||
                      (state == ST_ADDR && ab_q == LAST_AB && kind_q == CK_READ));
        fetch      = enter_tx || (state == ST_TX && need_next);
        fetch_kind = (state == ST_OP) ? op_kind : kind_q;
        fetch_addr = (state == ST_TX) ? addr_q : full_addr[ADDR_W-1:0];
    end

    // Source of the next output byte, two cycles after the fetch.
    always_comb begin
        tx_load = load_p2 && sel;
        case (kind_q)
            CK_READ: tx_byte = rd_data;
            CK_RDSR: tx_byte = status_byte;
            default: tx_byte = (id_sel == 2'd0) ? ID_MFR :
                               (id_sel == 2'd1) ? ID_DEV : 8'h00;
        endcase
    end

    // Frame state machine, command strobe and fetch bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_OP;
            kind_q       <= CK_NONE;
            bit_q        <= '0;
            ab_q         <= '0;
            shreg        <= '0;
            addr_acc     <= '0;
            addr_q       <= '0;
            id_q         <= '0;
            id_sel       <= '0;
            load_p1      <= 1'b0;
            load_p2      <= 1'b0;
            cmd_valid    <= 1'b0;
            cmd_kind     <= '0;
            cmd_addr     <= '0;
            cmd_data     <= '0;
            cmd_has_data <= 1'b0;
            rd_req       <= 1'b0;
            rd_addr      <= '0;
        end else begin
            cmd_valid <= 1'b0;
            rd_req    <= 1'b0;
            load_p1   <= fetch;
            load_p2   <= load_p1;
            if (!sel) begin
                state   <= ST_OP;
                kind_q  <= CK_NONE;
                bit_q   <= '0;
                id_q    <= '0;
                load_p1 <= 1'b0;
                load_p2 <= 1'b0;
            end else begin
                if (rise && (state == ST_OP || state == ST_ADDR || state == ST_DATA)) begin
                    shreg <= rx_byte;
                    bit_q <= bit_q + 3'd1;
                end
                if (byte_done) begin
                    unique case (state)
                        ST_OP: begin
                            kind_q <= op_kind;
                            ab_q   <= '0;
                            if (wr_busy && op_kind != CK_RDSR) begin
                                state <= ST_IGN;
                            end else begin
                                case (op_kind)
                                    CK_WREN, CK_WRDI: begin
                                        cmd_valid    <= 1'b1;
                                        cmd_kind     <= op_kind;
                                        cmd_has_data <= 1'b0;
                                        state        <= ST_IGN;
                                    end
                                    CK_RDSR, CK_RDID: state <= ST_TX;
                                    CK_WRSR:          state <= ST_DATA;
                                    CK_READ, CK_PROG, CK_SERASE, CK_CERASE:
                                                      state <= ST_ADDR;
                                    default:          state <= ST_IGN;
                                endcase
                            end
                        end
                        ST_ADDR: begin
                            addr_acc <= full_addr;
                            ab_q     <= ab_q + BC_W'(1);
                            if (ab_q == LAST_AB) begin
                                case (kind_q)
                                    CK_READ: state <= ST_TX;
                                    CK_PROG: begin
                                        addr_q <= full_addr[ADDR_W-1:0];
                                        state  <= ST_DATA;
                                    end
                                    default: begin
                                        cmd_valid    <= 1'b1;
                                        cmd_kind     <= kind_q;
                                        cmd_addr     <= full_addr[ADDR_W-1:0];
                                        cmd_has_data <= 1'b0;
                                        state        <= ST_IGN;
                                    end
                                endcase
                            end
                        end
                        ST_DATA: begin
                            cmd_valid    <= 1'b1;
                            cmd_kind     <= kind_q;
                            cmd_addr     <= addr_q;
                            cmd_data     <= rx_byte;
                            cmd_has_data <= 1'b1;
                            if (kind_q == CK_PROG)
                                addr_q <= {addr_q[ADDR_W-1:PAGE_W],
                                           addr_q[PAGE_W-1:0] + PAGE_W'(1)};
                            else
                                state <= ST_IGN;
                        end
                        default: ;
                    endcase
                end
                if (fetch) begin
                    if (fetch_kind == CK_READ) begin
                        rd_req  <= 1'b1;
                        rd_addr <= fetch_addr;
                        addr_q  <= fetch_addr + ADDR_W'(1);
                    end
                    if (fetch_kind == CK_RDID) begin
                        id_sel <= id_q;
                        if (id_q != 2'd2) id_q <= id_q + 2'd1;
                    end
                end
            end
        end
    end

    assign spi_so    = so_bit;
    assign spi_so_oe = sel && !paused && state == ST_TX;
endmodule

// File: rtl/sfc_checker.sv
// Property checker for the front end, bound to the top module.
module sfc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sel,
    input logic       paused,
    input logic       so_oe,
    input logic       cmd_valid,
    input logic [3:0] cmd_kind,
    input logic       cmd_has_data,
    input logic       rd_req
);
    p_no_strobe_deselected_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !cmd_valid);
    p_quiet_when_paused_r5: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> !so_oe);
    p_single_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);
    p_prog_carries_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 4'd4) |-> cmd_has_data);
    p_write_kind_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_kind >= 4'd1 && cmd_kind <= 4'd6));
    p_erase_no_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_kind == 4'd5 || cmd_kind == 4'd6)) |-> !cmd_has_data);
    p_strobe_one_cycle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
endmodule

bind sflash_cmd_front sfc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sel(sel), .paused(paused), .so_oe(spi_so_oe),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_has_data(cmd_has_data),
    .rd_req(rd_req)
);

// File: tb/sim_sflash_cmd_front.sv
module sim_sflash_cmd_front;
    localparam int CLK_PERIOD = 10;
    localparam int H = 6;

    logic clk = 0, rst_n = 0;
    logic sck = 0, cs_n = 1, si = 0, hold_n = 1, busy = 0;
    logic [7:0] status_byte = 8'h00, rd_data = 8'h00;
    logic so, so_oe, cmd_valid, cmd_has_data, rd_req;
    logic [3:0] cmd_kind;
    logic [17:0] cmd_addr, rd_addr;
    logic [7:0] cmd_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    sflash_cmd_front u0 (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
        .spi_hold_n(hold_n), .spi_so(so), .spi_so_oe(so_oe), .wr_busy(busy),
        .status_byte(status_byte), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_has_data(cmd_has_data),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [7:0] mem_f(input logic [17:0] a);
        return a[7:0] ^ a[15:8] ^ {6'd0, a[17:16]} ^ 8'h5A;
    endfunction

    // Array model with one cycle of read latency.
    always @(posedge clk) if (rd_req) rd_data <= mem_f(rd_addr);

    int vectors = 0, fails = 0, cycles = 0;
    int st_total = 0, rd_total = 0, oe_total = 0;
    logic [3:0]  lk [256];
    logic [17:0] la [256];
    logic [7:0]  ld [256];
    logic        lh [256];

    // Log strobes and count fetches and output-enable cycles.
    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (cmd_valid) begin
            lk[st_total % 256] <= cmd_kind;
            la[st_total % 256] <= cmd_addr;
            ld[st_total % 256] <= cmd_data;
            lh[st_total % 256] <= cmd_has_data;
            st_total <= st_total + 1;
        end
        if (rd_req) rd_total <= rd_total + 1;
        if (so_oe)  oe_total <= oe_total + 1;
        if (cycles > 190000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic       mode3 = 0;
    int         hold_byte = -1, hold_bit = 0;
    logic       hold_oe_seen;
    logic [7:0] txb [64];
    logic [7:0] rxb [64];

    // Pause in the middle of a bit slot with noise on clock and data.
    task automatic do_hold();
        waitc(H);
        hold_n = 0;
        waitc(H);
        hold_oe_seen = hold_oe_seen | so_oe;
        for (int t = 0; t < 3; t++) begin
            si = 1'($urandom); sck = 1; waitc(4); sck = 0; waitc(4);
            hold_oe_seen = hold_oe_seen | so_oe;
        end
        hold_n = 1;
        waitc(H);
    endtask

    task automatic frame(input int n);
        hold_oe_seen = 0;
        sck = mode3; waitc(2);
        cs_n = 0; waitc(H);
        for (int k = 0; k < n; k++) begin
            for (int i = 7; i >= 0; i--) begin
                sck = 0;
                if (k == hold_byte && i == hold_bit) do_hold();
                si = txb[k][i];
                waitc(H);
                rxb[k][i] = so;
                sck = 1;
                waitc(H);
            end
        end
        if (!mode3) begin sck = 0; waitc(H); end
        else waitc(H);
        cs_n = 1;
        waitc(3*H);
        hold_byte = -1;
    endtask

    task automatic run_read(input logic [23:0] a, input int n, input logic b3);
        int r0;
        r0 = rd_total;
        txb[0] = 8'h03 | {4'd0, b3, 3'd0};
        txb[1] = a[23:16]; txb[2] = a[15:8]; txb[3] = a[7:0];
        for (int i = 0; i < n; i++) txb[4+i] = 8'($urandom);
        frame(4 + n);
        for (int i = 0; i < n; i++)
            chk("R6 read byte", rxb[4+i], mem_f(a[17:0] + 18'(i)));
        chk("R6 one fetch per byte", rd_total - r0, n + 1);
        if (hold_byte >= 0) ;
    endtask

    task automatic run_prog(input logic [23:0] a, input int n);
        int s0;
        s0 = st_total;
        txb[0] = 8'h02 | {4'd0, 1'($urandom), 3'd0};
        txb[1] = a[23:16]; txb[2] = a[15:8]; txb[3] = a[7:0];
        for (int i = 0; i < n; i++) txb[4+i] = 8'($urandom);
        frame(4 + n);
        chk("R13 one strobe per program byte", st_total - s0, n);
        for (int i = 0; i < n; i++) begin
            chk("R10 program kind", lk[(s0+i)%256], 4'd4);
            chk("R2 R10 program address", la[(s0+i)%256],
                {a[17:8], 8'(a[7:0] + 8'(i))});
            chk("R2 program data", ld[(s0+i)%256], txb[4+i]);
            chk("R10 data valid", lh[(s0+i)%256], 1'b1);
        end
    endtask

    task automatic run_erase(input logic chip, input logic [23:0] a);
        int s0;
        s0 = st_total;
        txb[0] = chip ? 8'h6A : 8'h52;
        txb[1] = a[23:16]; txb[2] = a[15:8]; txb[3] = a[7:0];
        frame(4);
        chk("R12 erase strobe count", st_total - s0, 1);
        chk("R12 erase kind", lk[s0%256], chip ? 4'd6 : 4'd5);
        chk("R2 R12 erase address", la[s0%256], a[17:0]);
        chk("R12 erase no data", lh[s0%256], 1'b0);
    endtask

    task automatic run_id(input logic b3);
        txb[0] = 8'h15 | {4'd0, b3, 3'd0};
        txb[1] = 0; txb[2] = 0; txb[3] = 0;
        frame(4);
        chk("R7 id first", rxb[1], 8'h1F);
        chk("R7 id second", rxb[2], 8'h63);
        chk("R7 id after", rxb[3], 8'h00);
    endtask

    task automatic run_rdsr(input logic [7:0] st);
        status_byte = st;
        txb[0] = 8'h05; txb[1] = 0; txb[2] = 0;
        frame(3);
        chk("R8 status byte", rxb[1], st);
        chk("R8 status repeat", rxb[2], st);
    endtask

    initial begin
        int s0, r0, o0;
        waitc(4);
        rst_n = 1;
        waitc(4);
        chk("R3 reset oe", so_oe, 1'b0);
        chk("R3 reset strobe", cmd_valid, 1'b0);
        chk("R3 reset fetch", rd_req, 1'b0);

        // R1 R12: enable and disable, both bit-3 values
        s0 = st_total;
        txb[0] = 8'h06; frame(1);
        txb[0] = 8'h0E; mode3 = 1; frame(1); mode3 = 0;
        txb[0] = 8'h0C; frame(2);
        chk("R1 strobe count", st_total - s0, 3);
        chk("R1 R12 wren", lk[s0%256], 4'd1);
        chk("R1 wren bit3", lk[(s0+1)%256], 4'd1);
        chk("R1 R12 wrdi", lk[(s0+2)%256], 4'd2);

        // R12 R2 erases with ignored upper address bits
        run_erase(0, 24'hFC2345);
        run_erase(1, 24'h03FFFF);

        // R11 status write
        s0 = st_total;
        txb[0] = 8'h09; txb[1] = 8'h8C; txb[2] = 8'h55; frame(3);
        chk("R11 status write count", st_total - s0, 1);
        chk("R11 status write kind", lk[s0%256], 4'd3);
        chk("R11 status write data", ld[s0%256], 8'h8C);

        // R10 page wrap
        run_prog(24'h0123FC, 8);
        // R6 wrap at top, both modes
        run_read(24'h03FFFE, 4, 0);
        mode3 = 1; run_read(24'hFFFFFD, 4, 1); mode3 = 0;
        // R7
        run_id(0);
        mode3 = 1; run_id(1); mode3 = 0;

        // R8 R9 while busy
        busy = 1;
        run_rdsr(8'hA7);
        s0 = st_total; r0 = rd_total; o0 = oe_total;
        txb[0] = 8'h06; frame(1);
        txb[0] = 8'h03; txb[1] = 0; txb[2] = 0; txb[3] = 0; txb[4] = 0; frame(5);
        txb[0] = 8'h02; txb[5] = 8'h11; frame(6);
        chk("R9 no strobe busy", st_total - s0, 0);
        chk("R9 no fetch busy", rd_total - r0, 0);
        chk("R9 no output busy", oe_total - o0, 0);
        busy = 0;

        // R4 unknown opcode then recovery
        s0 = st_total; r0 = rd_total; o0 = oe_total;
        txb[0] = 8'hFF; txb[1] = 8'h06; txb[2] = 8'h03; txb[3] = 8'h00; frame(4);
        chk("R4 no strobe", st_total - s0, 0);
        chk("R4 no fetch", rd_total - r0, 0);
        chk("R4 no output", oe_total - o0, 0);
        run_read(24'h000100, 2, 0);

        // R3 frame cut by select
        s0 = st_total;
        txb[0] = 8'h52; txb[1] = 8'h01; frame(2);
        chk("R3 cut frame no strobe", st_total - s0, 0);

        // R5 pause during output and during address
        hold_byte = 5; hold_bit = 3;
        run_read(24'h012345, 3, 0);
        chk("R5 output quiet in pause", hold_oe_seen, 1'b0);
        hold_byte = 2; hold_bit = 6; mode3 = 1;
        run_prog(24'h02AB80, 2);
        mode3 = 0;

        // Random mix
        for (int it = 0; it < 24; it++) begin
            int c;
            logic [23:0] a;
            c = int'($urandom % 5);
            a = 24'($urandom);
            mode3 = 1'($urandom);
            if ($urandom % 3 == 0) begin
                hold_byte = int'($urandom % 5);
                hold_bit = int'($urandom % 8);
            end
            case (c)
                0: run_read(a, 1 + int'($urandom % 4), 1'($urandom));
                1: run_prog(a, 1 + int'($urandom % 4));
                2: run_id(1'($urandom));
                3: run_rdsr(8'($urandom));
                default: run_erase(1'($urandom), a);
            endcase
            hold_byte = -1;
        end
        mode3 = 0;

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end
endmodule